// File: doc/BRIEF.md
# Ordered Store Buffer with Write Fence

This block sits between a core's store port and its first-level data cache. A store whose target line the core already owns goes straight to the cache write port. A store to a line the core does not own is parked in an internal queue, and the block raises an ownership request for that line. The core keeps issuing stores and does not stall. Matching invalidation acknowledgements come back on a separate input, and the parked entries then drain to the cache from the oldest end. Coherence state tracking and the cache arrays live outside the block.

Loads from the same core probe the queue through a combinational lookup port. When several parked stores hit the probed word, the lookup returns the data and byte enables of the youngest one. Other cores never see the queue contents.

A write-fence input puts an ordering point into the store stream. Every entry present in that cycle is marked. From then on every new store is queued unmarked, even a store to an owned line, until all marked entries have left for the cache. The queue therefore drains the pre-fence stores before any post-fence store becomes visible.

Top module: `st_order_buf`

## Requirements
- R1: With no fence pending and no queued entry on the same line, a store flagged as owned is accepted and shows up on the cache write port in the cycle after acceptance, and it does not enter the queue.
- R2: A store not flagged as owned is queued with a waiting flag set. In the cycle after acceptance an ownership request pulse carries its line address (byte address bits 31..6), and the store produces no cache write while it waits.
- R3: An acknowledgement whose line address matches clears the waiting flag of every queued entry on that line. An acknowledgement for any other line changes nothing. Entries leave for the cache strictly from the oldest end, and only when the oldest entry is no longer waiting.
- R4: With no fence pending, an owned store to a line with no queued entry may write the cache before older queued stores that are still waiting.
- R5: An owned store to a line that already has a queued entry is queued behind it and never overtakes it.
- R6: The load lookup compares word addresses (bits 31..2). On a hit it returns the data and byte enables of the youngest matching entry. With no match it reports a miss.
- R7: A fence marks every entry in the queue at that moment. While any marked entry remains queued, every accepted store is queued, owned or not.
- R8: Once the marked entries are acknowledged, they are written to the cache before any store accepted after the fence, in program order.
- R9: The queue holds DEPTH (8) entries. When it is full, st_ready is low and a presented store is neither written nor queued.
- R10: A store accepted in the same cycle as a fence is ordered after that fence.
- R11: Right after reset, st_ready is high and cw_valid, own_req_valid and ld_hit are low.
- R12: When a direct owned store and a drain of the oldest entry fall in the same cycle, the direct store takes the cache write port, and the drain follows in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| st_valid | input | 1 | Store request valid |
| st_ready | output | 1 | Store port can accept (queue not full) |
| st_addr | input | 32 | Store byte address |
| st_data | input | 32 | Store data word |
| st_be | input | 4 | Store byte enables |
| st_owned | input | 1 | Target line currently held Modified or Exclusive |
| wbar | input | 1 | Write-fence pulse |
| inv_ack_valid | input | 1 | Invalidation acknowledgement valid |
| inv_ack_line | input | 26 | Line address of the acknowledgement |
| own_req_valid | output | 1 | Ownership request pulse |
| own_req_line | output | 26 | Line address of the ownership request |
| cw_valid | output | 1 | Cache write valid |
| cw_addr | output | 32 | Cache write byte address |
| cw_data | output | 32 | Cache write data |
| cw_be | output | 4 | Cache write byte enables |
| ld_addr | input | 32 | Load lookup address |
| ld_hit | output | 1 | Lookup found a queued store to that word |
| ld_data | output | 32 | Data of the youngest matching entry |
| ld_be | output | 4 | Byte enables of the youngest matching entry |

## Verification
Two pairs of functions can land in one cycle. In the first, an owned store arrives just as the oldest queued entry becomes eligible to drain. The bench provokes this by presenting the store in the cycle right after the acknowledgement that frees the oldest entry. It judges the result from the order of cache writes: the direct store comes first and the drained entry lands exactly one write later. In the second, a fence and an owned store arrive together while an entry is waiting. The store must not reach the cache until the acknowledgement arrives and the older entry has been written.

// File: rtl/stq_pkg.sv
package stq_pkg;
  parameter int ADDR_W   = 32;
  parameter int DATA_W   = 32;
  parameter int LINE_OFF = 6;
  localparam int BE_W     = DATA_W / 8;
  localparam int WORD_OFF = $clog2(BE_W);
  localparam int LINE_W   = ADDR_W - LINE_OFF;

  typedef struct packed {
    logic              valid;
    logic              waiting;
    logic              mark;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
    logic [BE_W-1:0]   be;
  } stq_ent_t;
endpackage

// File: rtl/stq_array.sv
module stq_array
  import stq_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  push_i,
  input  stq_ent_t              push_ent_i,
  input  logic                  pop_i,
  input  logic                  bar_i,
  input  logic                  ack_vld_i,
  input  logic [LINE_W-1:0]     ack_line_i,
  output stq_ent_t [DEPTH-1:0]  ents_o,
  output logic [CNT_W-1:0]      cnt_o
);

  stq_ent_t [DEPTH-1:0] ents_q, upd, ents_d;
  logic [CNT_W-1:0]     cnt_q, cnt_d, wr_idx;
  logic                 state_en;
  logic                 mark_gap;

  // acknowledgement clear and fence marking on resident entries
  always_comb begin
    upd = ents_q;
    for (int i = 0; i < DEPTH; i++) begin
      if (ents_q[i].valid) begin
        if (ack_vld_i && (ents_q[i].addr[ADDR_W-1:LINE_OFF] == ack_line_i))
          upd[i].waiting = 1'b0;
        if (bar_i)
          upd[i].mark = 1'b1;
      end
    end
  end

  // shift-down on pop, append at the tail on push
  always_comb begin
    wr_idx = cnt_q - CNT_W'(pop_i);
    if (pop_i) begin
      for (int i = 0; i < DEPTH - 1; i++) ents_d[i] = upd[i+1];
      ents_d[DEPTH-1] = '0;
    end else begin
      ents_d = upd;
    end
    for (int i = 0; i < DEPTH; i++) begin
      if (push_i && (CNT_W'(i) == wr_idx)) ents_d[i] = push_ent_i;
    end
    cnt_d    = cnt_q + CNT_W'(push_i) - CNT_W'(pop_i);
    state_en = push_i | pop_i | bar_i | ack_vld_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ents_q <= '0;
      cnt_q  <= '0;
    end else if (state_en) begin
      ents_q <= ents_d;
      cnt_q  <= cnt_d;
    end
  end

  assign ents_o = ents_q;
  assign cnt_o  = cnt_q;

  always_comb begin
    mark_gap = 1'b0;
    for (int i = 1; i < DEPTH; i++) begin
      if (ents_q[i].valid && ents_q[i].mark && !ents_q[i-1].mark) mark_gap = 1'b1;
    end
  end

  // R9: a push only ever lands in a free slot
  a_r9_push_room: assert property (@(posedge clk) disable iff (!rst_n)
    push_i |-> (cnt_q < CNT_W'(DEPTH)));

  // R3: only a valid, acknowledged head leaves the queue
  a_r3_pop_ready: assert property (@(posedge clk) disable iff (!rst_n)
    pop_i |-> (ents_q[0].valid && !ents_q[0].waiting));

  // R8: marked entries always form an unbroken run at the oldest end
  a_r8_mark_prefix: assert property (@(posedge clk) disable iff (!rst_n)
    !mark_gap);

endmodule

// File: rtl/stq_search.sv
module stq_search
  import stq_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  stq_ent_t [DEPTH-1:0] ents_i,
  input  logic [ADDR_W-1:0]    ld_addr_i,
  input  logic [ADDR_W-1:0]    line_addr_i,
  output logic                 ld_hit_o,
  output logic [DATA_W-1:0]    ld_data_o,
  output logic [BE_W-1:0]      ld_be_o,
  output logic                 line_hit_o
);

  // later index is younger, so the last match wins
  always_comb begin
    ld_hit_o   = 1'b0;
    ld_data_o  = '0;
    ld_be_o    = '0;
    line_hit_o = 1'b0;
    for (int i = 0; i < DEPTH; i++) begin
      if (ents_i[i].valid && (((ents_i[i].addr ^ ld_addr_i) >> WORD_OFF) == '0)) begin
        ld_hit_o  = 1'b1;
        ld_data_o = ents_i[i].data;
        ld_be_o   = ents_i[i].be;
      end
      if (ents_i[i].valid && (((ents_i[i].addr ^ line_addr_i) >> LINE_OFF) == '0))
        line_hit_o = 1'b1;
    end
  end

endmodule

// File: rtl/stq_wport.sv
module stq_wport
  import stq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dir_i,
  input  logic [ADDR_W-1:0] dir_addr_i,
  input  logic [DATA_W-1:0] dir_data_i,
  input  logic [BE_W-1:0]   dir_be_i,
  input  logic              pop_i,
  input  logic [ADDR_W-1:0] head_addr_i,
  input  logic [DATA_W-1:0] head_data_i,
  input  logic [BE_W-1:0]   head_be_i,
  output logic              cw_valid_o,
  output logic [ADDR_W-1:0] cw_addr_o,
  output logic [DATA_W-1:0] cw_data_o,
  output logic [BE_W-1:0]   cw_be_o
);

  logic              vld_d;
  logic [ADDR_W-1:0] addr_d;
  logic [DATA_W-1:0] data_d;
  logic [BE_W-1:0]   be_d;

  always_comb begin
    vld_d  = dir_i | pop_i;
    addr_d = dir_i ? dir_addr_i : head_addr_i;
    data_d = dir_i ? dir_data_i : head_data_i;
    be_d   = dir_i ? dir_be_i   : head_be_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cw_valid_o <= 1'b0;
      cw_addr_o  <= '0;
      cw_data_o  <= '0;
      cw_be_o    <= '0;
    end else begin
      cw_valid_o <= vld_d;
      if (vld_d) begin
        cw_addr_o <= addr_d;
        cw_data_o <= data_d;
        cw_be_o   <= be_d;
      end
    end
  end

endmodule

// File: rtl/st_order_buf.sv
module st_order_buf
  import stq_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              st_valid,
  output logic              st_ready,
  input  logic [ADDR_W-1:0] st_addr,
  input  logic [DATA_W-1:0] st_data,
  input  logic [BE_W-1:0]   st_be,
  input  logic              st_owned,
  input  logic              wbar,
  input  logic              inv_ack_valid,
  input  logic [LINE_W-1:0] inv_ack_line,
  output logic              own_req_valid,
  output logic [LINE_W-1:0] own_req_line,
  output logic              cw_valid,
  output logic [ADDR_W-1:0] cw_addr,
  output logic [DATA_W-1:0] cw_data,
  output logic [BE_W-1:0]   cw_be,
  input  logic [ADDR_W-1:0] ld_addr,
  output logic              ld_hit,
  output logic [DATA_W-1:0] ld_data,
  output logic [BE_W-1:0]   ld_be
);

  localparam int CNT_W = $clog2(DEPTH + 1);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       srst_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign srst_n = rst_sync_q[1];

  stq_ent_t [DEPTH-1:0] ents;
  stq_ent_t             push_ent;
  logic [CNT_W-1:0]     cnt;
  logic                 line_hit, fence, any_valid, fence_eff;
  logic                 st_fire, to_buf, direct, push, pop;
  logic                 req_vld_d;

  always_comb begin
    fence     = 1'b0;
    any_valid = 1'b0;
    for (int i = 0; i < DEPTH; i++) begin
      if (ents[i].valid && ents[i].mark) fence = 1'b1;
      if (ents[i].valid) any_valid = 1'b1;
    end
    fence_eff = fence | (wbar & any_valid);
    st_ready  = (cnt < CNT_W'(DEPTH));
    st_fire   = st_valid & st_ready;
    to_buf    = ~st_owned | fence_eff | line_hit;
    direct    = st_fire & ~to_buf;
    push      = st_fire & to_buf;
    pop       = ents[0].valid & ~ents[0].waiting & ~direct;
    req_vld_d = push & ~st_owned;

    push_ent         = '0;
    push_ent.valid   = 1'b1;
    push_ent.waiting = ~st_owned;
    push_ent.addr    = st_addr;
    push_ent.data    = st_data;
    push_ent.be      = st_be;
  end

  stq_array #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_array (
    .clk        (clk),
    .rst_n      (srst_n),
    .push_i     (push),
    .push_ent_i (push_ent),
    .pop_i      (pop),
    .bar_i      (wbar),
    .ack_vld_i  (inv_ack_valid),
    .ack_line_i (inv_ack_line),
    .ents_o     (ents),
    .cnt_o      (cnt)
  );

  stq_search #(.DEPTH(DEPTH)) u_search (
    .ents_i      (ents),
    .ld_addr_i   (ld_addr),
    .line_addr_i (st_addr),
    .ld_hit_o    (ld_hit),
    .ld_data_o   (ld_data),
    .ld_be_o     (ld_be),
    .line_hit_o  (line_hit)
  );

  stq_wport u_wport (
    .clk         (clk),
    .rst_n       (srst_n),
    .dir_i       (direct),
    .dir_addr_i  (st_addr),
    .dir_data_i  (st_data),
    .dir_be_i    (st_be),
    .pop_i       (pop),
    .head_addr_i (ents[0].addr),
    .head_data_i (ents[0].data),
    .head_be_i   (ents[0].be),
    .cw_valid_o  (cw_valid),
    .cw_addr_o   (cw_addr),
    .cw_data_o   (cw_data),
    .cw_be_o     (cw_be)
  );

  // ownership request register
  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      own_req_valid <= 1'b0;
      own_req_line  <= '0;
    end else begin
      own_req_valid <= req_vld_d;
      if (req_vld_d) own_req_line <= st_addr[ADDR_W-1:LINE_OFF];
    end
  end

  // R2: an unowned store raises an ownership request next cycle
  a_r2_req_pulse: assert property (@(posedge clk) disable iff (!srst_n)
    (st_fire && !st_owned) |=> own_req_valid);

  // R1: a direct store appears on the cache port next cycle
  a_r1_direct_write: assert property (@(posedge clk) disable iff (!srst_n)
    direct |=> (cw_valid && (cw_addr == $past(st_addr))));

  // R7: under a fence every accepted store grows the queue
  a_r7_fence_queues: assert property (@(posedge clk) disable iff (!srst_n)
    (st_fire && fence_eff) |=> (cnt == ($past(cnt) + CNT_W'(1) - CNT_W'($past(pop)))));

endmodule

// File: tb/st_order_buf_bench.sv
module st_order_buf_bench;
  import stq_pkg::*;

  localparam int CLK_PERIOD = 10;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              st_valid, st_ready, st_owned, wbar;
  logic [ADDR_W-1:0] st_addr, ld_addr, cw_addr;
  logic [DATA_W-1:0] st_data, cw_data, ld_data;
  logic [BE_W-1:0]   st_be, cw_be, ld_be;
  logic              inv_ack_valid, own_req_valid, cw_valid, ld_hit;
  logic [LINE_W-1:0] inv_ack_line, own_req_line;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;
  logic [ADDR_W-1:0] log_a [0:63];
  logic [DATA_W-1:0] log_d [0:63];
  int log_n = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  st_order_buf u_st_order_buf (
    .clk(clk), .rst_n(rst_n), .st_valid(st_valid), .st_ready(st_ready),
    .st_addr(st_addr), .st_data(st_data), .st_be(st_be), .st_owned(st_owned),
    .wbar(wbar), .inv_ack_valid(inv_ack_valid), .inv_ack_line(inv_ack_line),
    .own_req_valid(own_req_valid), .own_req_line(own_req_line),
    .cw_valid(cw_valid), .cw_addr(cw_addr), .cw_data(cw_data), .cw_be(cw_be),
    .ld_addr(ld_addr), .ld_hit(ld_hit), .ld_data(ld_data), .ld_be(ld_be)
  );

  always @(negedge clk) begin
    if (rst_n && cw_valid && log_n < 64) begin
      log_a[log_n] = cw_addr;
      log_d[log_n] = cw_data;
      log_n++;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic idle(input int n);
    repeat (n) tick();
  endtask

  task automatic store(input logic [31:0] a, input logic [31:0] d, input logic [3:0] be, input bit own);
    st_valid = 1'b1; st_addr = a; st_data = d; st_be = be; st_owned = own;
    tick();
    st_valid = 1'b0;
  endtask

  task automatic ack(input logic [31:0] a);
    inv_ack_valid = 1'b1; inv_ack_line = a[31:6];
    tick();
    inv_ack_valid = 1'b0;
  endtask

  task automatic fence();
    wbar = 1'b1;
    tick();
    wbar = 1'b0;
  endtask

  task automatic expect_log(input int idx, input logic [31:0] a, input logic [31:0] d, input string req);
    chk(log_n > idx && log_a[idx] == a && log_d[idx] == d, req,
        {log_a[idx], log_d[idx]}, {a, d});
  endtask

  task automatic t_reset();
    chk(st_ready == 1'b1, "R11 ready", 64'(st_ready), 64'd1);
    chk(cw_valid == 1'b0, "R11 cw_valid", 64'(cw_valid), 64'd0);
    chk(own_req_valid == 1'b0, "R11 own_req", 64'(own_req_valid), 64'd0);
    chk(ld_hit == 1'b0, "R11 ld_hit", 64'(ld_hit), 64'd0);
  endtask

  task automatic t_direct();
    int b = log_n;
    store(32'h100, 32'h11, 4'hF, 1'b1);
    chk(cw_valid && cw_addr == 32'h100, "R1 direct timing", 64'(cw_addr), 64'h100);
    ld_addr = 32'h100; #1;
    chk(ld_hit == 1'b0, "R1 not queued", 64'(ld_hit), 64'd0);
    idle(2);
    expect_log(b, 32'h100, 32'h11, "R1 write");
  endtask

  task automatic t_park_ack();
    int b = log_n;
    store(32'h200, 32'h22, 4'hF, 1'b0);
    chk(own_req_valid && own_req_line == 26'h8, "R2 own req", 64'(own_req_line), 64'h8);
    idle(3);
    chk(log_n == b, "R2 held", 64'(log_n), 64'(b));
    ack(32'h240);
    idle(2);
    chk(log_n == b, "R3 other line ignored", 64'(log_n), 64'(b));
    ld_addr = 32'h200; #1;
    chk(ld_hit == 1'b1, "R3 still queued", 64'(ld_hit), 64'd1);
    ack(32'h200);
    idle(3);
    expect_log(b, 32'h200, 32'h22, "R3 drain");
  endtask

  task automatic t_reorder();
    int b = log_n;
    store(32'h300, 32'h33, 4'hF, 1'b0);
    store(32'h400, 32'h44, 4'hF, 1'b1);
    idle(2);
    chk(log_n == b + 1, "R4 one write", 64'(log_n), 64'(b + 1));
    expect_log(b, 32'h400, 32'h44, "R4 younger first");
    ack(32'h300);
    idle(3);
    expect_log(b + 1, 32'h300, 32'h33, "R4 older later");
  endtask

  task automatic t_same_line();
    int b = log_n;
    store(32'h500, 32'h55, 4'hF, 1'b0);
    store(32'h504, 32'h56, 4'hF, 1'b1);
    idle(2);
    chk(log_n == b, "R5 no overtake", 64'(log_n), 64'(b));
    ack(32'h500);
    idle(4);
    expect_log(b, 32'h500, 32'h55, "R5 order first");
    expect_log(b + 1, 32'h504, 32'h56, "R5 order second");
  endtask

  task automatic t_forward();
    store(32'h600, 32'h61, 4'hF, 1'b0);
    store(32'h600, 32'h62, 4'h3, 1'b0);
    ld_addr = 32'h600; #1;
    chk(ld_hit && ld_data == 32'h62 && ld_be == 4'h3, "R6 youngest",
        {ld_data, 28'h0, ld_be}, {32'h62, 28'h0, 4'h3});
    ld_addr = 32'h604; #1;
    chk(ld_hit == 1'b0, "R6 other word", 64'(ld_hit), 64'd0);
    ld_addr = 32'h700; #1;
    chk(ld_hit == 1'b0, "R6 other line", 64'(ld_hit), 64'd0);
    ack(32'h600);
    idle(4);
  endtask

  task automatic t_fence();
    int b = log_n;
    store(32'h800, 32'h81, 4'hF, 1'b0);
    fence();
    store(32'h900, 32'h91, 4'hF, 1'b1);
    store(32'hA00, 32'hA1, 4'hF, 1'b0);
    idle(3);
    chk(log_n == b, "R7 owned store held", 64'(log_n), 64'(b));
    ld_addr = 32'h900; #1;
    chk(ld_hit == 1'b1, "R7 owned store queued", 64'(ld_hit), 64'd1);
    ack(32'hA00);
    idle(3);
    chk(log_n == b, "R8 younger waits", 64'(log_n), 64'(b));
    ack(32'h800);
    idle(5);
    expect_log(b, 32'h800, 32'h81, "R8 marked first");
    expect_log(b + 1, 32'h900, 32'h91, "R8 second");
    expect_log(b + 2, 32'hA00, 32'hA1, "R8 third");
  endtask

  task automatic t_fence_same();
    int b = log_n;
    store(32'hB00, 32'hB1, 4'hF, 1'b0);
    wbar = 1'b1;
    store(32'hC00, 32'hC1, 4'hF, 1'b1);
    wbar = 1'b0;
    idle(2);
    chk(log_n == b, "R10 store after fence held", 64'(log_n), 64'(b));
    ack(32'hB00);
    idle(4);
    expect_log(b, 32'hB00, 32'hB1, "R10 order first");
    expect_log(b + 1, 32'hC00, 32'hC1, "R10 order second");
  endtask

  task automatic t_full();
    int b = log_n;
    for (int i = 0; i < 8; i++) store(32'h1000 + 32'(i) * 32'h40, 32'h1000 + 32'(i), 4'hF, 1'b0);
    chk(st_ready == 1'b0, "R9 ready low", 64'(st_ready), 64'd0);
    st_valid = 1'b1; st_addr = 32'h2000; st_data = 32'hDEAD; st_be = 4'hF; st_owned = 1'b1;
    tick();
    st_valid = 1'b0;
    idle(2);
    chk(log_n == b, "R9 refused no write", 64'(log_n), 64'(b));
    ld_addr = 32'h2000; #1;
    chk(ld_hit == 1'b0, "R9 refused not queued", 64'(ld_hit), 64'd0);
    for (int i = 0; i < 8; i++) ack(32'h1000 + 32'(i) * 32'h40);
    idle(12);
    for (int i = 0; i < 8; i++)
      expect_log(b + i, 32'h1000 + 32'(i) * 32'h40, 32'h1000 + 32'(i), "R9 drain order");
    chk(st_ready == 1'b1, "R9 ready back", 64'(st_ready), 64'd1);
  endtask

  task automatic t_contend();
    int b = log_n;
    store(32'hE00, 32'hE1, 4'hF, 1'b0);
    inv_ack_valid = 1'b1; inv_ack_line = 26'h38;
    tick();
    inv_ack_valid = 1'b0;
    store(32'hF00, 32'hF1, 4'hF, 1'b1);
    idle(3);
    expect_log(b, 32'hF00, 32'hF1, "R12 direct wins");
    expect_log(b + 1, 32'hE00, 32'hE1, "R12 drain follows");
  endtask

  initial begin
    rst_n = 1'b0; st_valid = 1'b0; st_addr = '0; st_data = '0; st_be = '0;
    st_owned = 1'b0; wbar = 1'b0; inv_ack_valid = 1'b0; inv_ack_line = '0; ld_addr = '0;
    idle(3);
    rst_n = 1'b1;
    idle(3);
    t_reset();
    t_direct();
    t_park_ack();
    t_reorder();
    t_same_line();
    t_forward();
    t_fence();
    t_fence_same();
    t_full();
    t_contend();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

endmodule